// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between a CPU's load/store unit and its small private data cache. A store to a line that the cache holds with write ownership (modified or exclusive) is written into the cache in the same cycle. A store to any other line is queued in a four-entry, program-ordered buffer, and the block sends one read-invalidate request for that line to the interconnect. Every load looks up the cache and the buffer in the same cycle. Buffered bytes override the cache bytes, so the CPU always sees its own stores in program order.

When the interconnect reports that a requested line has arrived, every queued entry for that line becomes ready. A small drain state machine then writes ready entries from the head of the queue into the cache, one at a time and oldest first. The drain machine has two states. DR_IDLE moves to DR_WRITE when the head entry is valid and its line has arrived. DR_WRITE always returns to DR_IDLE after one cycle. The cache write happens during the DR_WRITE cycle, and the entry is freed at the end of that cycle. A head entry whose line has not arrived holds back every younger entry, including entries whose own line has already arrived.

The cache has a single write port. When the drain machine holds that port, a store that would write the cache directly is stalled for that cycle.

Top module: `sbf_top`

## Requirements
- R1: During and right after reset the buffer is empty. `cpu_stall`, `rq_valid` and `cwr_en` are all low.
- R2: A store to a line reported owned (`lk_own`=1) that has no queued entry, and that is not stalled, is written to the cache in the same cycle. In that cycle `cwr_en`=1, `cwr_addr`=`cpu_addr`, `cwr_data`=`cpu_wdata` and `cwr_be`=`cpu_be`. No request is issued for it.
- R3: An accepted store to a non-owned line that has neither a pending request nor an arrived fill is queued. In the following cycle `rq_valid` is high for one cycle, with `rq_line` equal to the store's line (`cpu_addr[7:2]`, four words per line).
- R4: A store to a line that already has a pending request adds a queue entry but raises no new `rq_valid`.
- R5: `cpu_rdata` is formed in the same cycle as the load. Each byte lane (bit 8k+7..8k is lane k, selected by `cpu_be[k]`) comes from the youngest queued entry with the same word address that enables that lane. A lane that no such entry enables comes from `lk_rdata`.
- R6: After `fill_valid` is high with `fill_line` equal to a queued line, the entries for that line are written to the cache through `cwr_*` in program order. Once they drain, the cache holds every store in program order.
- R7: Entries drain strictly from the head of the queue. An entry whose line has not arrived blocks all younger entries, even ones whose fill has already arrived.
- R8: When four entries are queued, a store that needs the buffer sees `cpu_stall`=1 and is not accepted. Loads are served normally while the buffer is full.
- R9: During a drain write cycle, a store bound for direct cache write sees `cpu_stall`=1 and the drain entry is written first. The store is written in the next cycle if no other drain write occupies it.
- R10: A store to a line accepted in the same cycle as that line's fill is queued as already arrived. It issues no request and drains with the other entries for that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | CPU access valid this cycle |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 8 | Word address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte lane enables |
| cpu_rdata | output | 32 | Load data, cache merged with buffer |
| cpu_stall | output | 1 | Store not accepted this cycle |
| lk_addr | output | 8 | Cache lookup address |
| lk_own | input | 1 | Looked-up line held with write ownership |
| lk_rdata | input | 32 | Cache word at `lk_addr` |
| cwr_en | output | 1 | Cache write strobe |
| cwr_addr | output | 8 | Cache write word address |
| cwr_data | output | 32 | Cache write data |
| cwr_be | output | 4 | Cache write byte enables |
| rq_valid | output | 1 | Read-invalidate request pulse |
| rq_line | output | 6 | Requested line address |
| fill_valid | input | 1 | Requested line has arrived in the cache |
| fill_line | input | 6 | Line address of the arrival |

## Verification
Two pairs of functions can fall in the same cycle. The first is a drain write and a direct store to an owned line, which compete for the single cache write port. The bench times a fill so that the drain machine reaches DR_WRITE exactly when a direct store is presented. It expects a stall with the queued address on `cwr_addr`, then the store's own address one cycle later. The second pair is a store and the fill of that store's line. The bench presents them together and judges the outcome by the absence of a request pulse in the next cycle and by the final cache contents.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
    typedef enum logic [0:0] {
        DR_IDLE  = 1'b0,
        DR_WRITE = 1'b1
    } drain_state_e;
endpackage

// File: rtl/sbf_fifo.sv
module sbf_fifo #(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    parameter int LWB   = 2,
    localparam int BW   = DW / 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [AW-1:0]     push_addr,
    input  logic [DW-1:0]     push_data,
    input  logic [BW-1:0]     push_be,
    input  logic              push_filled,
    input  logic              pop,
    input  logic              mark_en,
    input  logic [AW-LWB-1:0] mark_line,
    output logic [CW-1:0]     count,
    output logic              full,
    output logic [AW-1:0]     q_addr   [DEPTH],
    output logic [DW-1:0]     q_data   [DEPTH],
    output logic [BW-1:0]     q_be     [DEPTH],
    output logic              q_filled [DEPTH]
);
    logic [AW-1:0] n_addr   [DEPTH];
    logic [DW-1:0] n_data   [DEPTH];
    logic [BW-1:0] n_be     [DEPTH];
    logic          n_filled [DEPTH];
    logic [CW-1:0] n_count;
    logic [IW-1:0] widx;

    assign full = (count == CW'(DEPTH));

    always_comb begin
        n_addr   = q_addr;
        n_data   = q_data;
        n_be     = q_be;
        n_filled = q_filled;
        n_count  = count;
        widx     = '0;
        if (mark_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) < count && q_addr[i][AW-1:LWB] == mark_line)
                    n_filled[i] = 1'b1;
            end
        end
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                n_addr[i]   = n_addr[i+1];
                n_data[i]   = n_data[i+1];
                n_be[i]     = n_be[i+1];
                n_filled[i] = n_filled[i+1];
            end
            n_addr[DEPTH-1]   = '0;
            n_data[DEPTH-1]   = '0;
            n_be[DEPTH-1]     = '0;
            n_filled[DEPTH-1] = 1'b0;
            n_count           = n_count - CW'(1);
        end
        if (push) begin
            widx           = n_count[IW-1:0];
            n_addr[widx]   = push_addr;
            n_data[widx]   = push_data;
            n_be[widx]     = push_be;
            n_filled[widx] = push_filled;
            n_count        = n_count + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                q_addr[i]   <= '0;
                q_data[i]   <= '0;
                q_be[i]     <= '0;
                q_filled[i] <= 1'b0;
            end
        end else begin
            count    <= n_count;
            q_addr   <= n_addr;
            q_data   <= n_data;
            q_be     <= n_be;
            q_filled <= n_filled;
        end
    end
endmodule

// File: rtl/sbf_fwd.sv
module sbf_fwd #(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    parameter int LWB   = 2,
    localparam int BW   = DW / 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] q_addr   [DEPTH],
    input  logic [DW-1:0] q_data   [DEPTH],
    input  logic [BW-1:0] q_be     [DEPTH],
    input  logic          q_filled [DEPTH],
    input  logic [AW-1:0] look_addr,
    input  logic [DW-1:0] cache_word,
    output logic [DW-1:0] merged,
    output logic          has_entry,
    output logic          has_unfilled,
    output logic          has_filled
);
    always_comb begin
        merged       = cache_word;
        has_entry    = 1'b0;
        has_unfilled = 1'b0;
        has_filled   = 1'b0;
        // oldest first, so the youngest matching lane wins
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < count) begin
                if (q_addr[i][AW-1:LWB] == look_addr[AW-1:LWB]) begin
                    has_entry = 1'b1;
                    if (q_filled[i]) has_filled   = 1'b1;
                    else             has_unfilled = 1'b1;
                end
                if (q_addr[i] == look_addr) begin
                    for (int b = 0; b < BW; b++) begin
                        if (q_be[i][b]) merged[b*8 +: 8] = q_data[i][b*8 +: 8];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sbf_drain.sv
module sbf_drain
    import sbf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic head_valid,
    input  logic head_filled,
    output logic wr_active,
    output logic pop
);
    drain_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= DR_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DR_IDLE:  if (head_valid && head_filled) state_d = DR_WRITE;
            DR_WRITE: state_d = DR_IDLE;
        endcase
    end

    always_comb begin
        wr_active = 1'b0;
        pop       = 1'b0;
        unique case (state_q)
            DR_IDLE:  ;
            DR_WRITE: begin
                wr_active = 1'b1;
                pop       = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/sbf_top.sv
module sbf_top #(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    parameter int LWB   = 2,
    localparam int BW   = DW / 8,
    localparam int LNW  = AW - LWB,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cpu_req,
    input  logic           cpu_we,
    input  logic [AW-1:0]  cpu_addr,
    input  logic [DW-1:0]  cpu_wdata,
    input  logic [BW-1:0]  cpu_be,
    output logic [DW-1:0]  cpu_rdata,
    output logic           cpu_stall,
    output logic [AW-1:0]  lk_addr,
    input  logic           lk_own,
    input  logic [DW-1:0]  lk_rdata,
    output logic           cwr_en,
    output logic [AW-1:0]  cwr_addr,
    output logic [DW-1:0]  cwr_data,
    output logic [BW-1:0]  cwr_be,
    output logic           rq_valid,
    output logic [LNW-1:0] rq_line,
    input  logic           fill_valid,
    input  logic [LNW-1:0] fill_line
);
    logic [CW-1:0] count;
    logic          full;
    logic [AW-1:0] q_addr   [DEPTH];
    logic [DW-1:0] q_data   [DEPTH];
    logic [BW-1:0] q_be     [DEPTH];
    logic          q_filled [DEPTH];

    logic has_entry, has_unfilled, has_filled;
    logic drain_wr, drain_pop;
    logic is_store, direct, fill_hit, push, push_filled, need_req;

    assign lk_addr  = cpu_addr;
    assign is_store = cpu_req && cpu_we;
    assign direct   = lk_own && !has_entry;
    assign fill_hit = fill_valid && (fill_line == cpu_addr[AW-1:LWB]);

    assign cpu_stall   = is_store && (direct ? drain_wr : full);
    assign push        = is_store && !direct && !full;
    assign push_filled = has_filled || fill_hit;
    assign need_req    = push && !has_unfilled && !push_filled;

    always_comb begin
        cwr_en   = 1'b0;
        cwr_addr = cpu_addr;
        cwr_data = cpu_wdata;
        cwr_be   = cpu_be;
        if (drain_wr) begin
            cwr_en   = 1'b1;
            cwr_addr = q_addr[0];
            cwr_data = q_data[0];
            cwr_be   = q_be[0];
        end else if (is_store && direct) begin
            cwr_en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rq_valid <= 1'b0;
            rq_line  <= '0;
        end else begin
            rq_valid <= need_req;
            if (need_req) rq_line <= cpu_addr[AW-1:LWB];
        end
    end

    sbf_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .LWB(LWB)) u_fifo (
        .clk(clk), .rst(rst),
        .push(push), .push_addr(cpu_addr), .push_data(cpu_wdata),
        .push_be(cpu_be), .push_filled(push_filled),
        .pop(drain_pop), .mark_en(fill_valid), .mark_line(fill_line),
        .count(count), .full(full),
        .q_addr(q_addr), .q_data(q_data), .q_be(q_be), .q_filled(q_filled)
    );

    sbf_fwd #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .LWB(LWB)) u_fwd (
        .count(count), .q_addr(q_addr), .q_data(q_data), .q_be(q_be),
        .q_filled(q_filled), .look_addr(cpu_addr), .cache_word(lk_rdata),
        .merged(cpu_rdata), .has_entry(has_entry),
        .has_unfilled(has_unfilled), .has_filled(has_filled)
    );

    sbf_drain u_drain (
        .clk(clk), .rst(rst),
        .head_valid(count != '0), .head_filled(q_filled[0]),
        .wr_active(drain_wr), .pop(drain_pop)
    );
endmodule

// File: rtl/sbf_chk.sv
module sbf_chk #(
    parameter int AW  = 8,
    parameter int LWB = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [AW-1:0]     cpu_addr,
    input logic              cpu_stall,
    input logic              lk_own,
    input logic              rq_valid,
    input logic [AW-LWB-1:0] rq_line,
    input logic              fill_valid,
    input logic [AW-LWB-1:0] fill_line
);
    AST_STALL_IS_STORE: assert property (@(posedge clk) disable iff (rst)
        cpu_stall |-> (cpu_req && cpu_we)); // R8

    AST_OWNED_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && !cpu_stall && lk_own) |=> !rq_valid); // R2

    AST_REQ_FROM_STORE: assert property (@(posedge clk) disable iff (rst)
        rq_valid |-> $past(cpu_req && cpu_we && !cpu_stall && !lk_own)); // R3

    AST_REQ_LINE: assert property (@(posedge clk) disable iff (rst)
        rq_valid |-> (rq_line == $past(cpu_addr[AW-1:LWB]))); // R3

    AST_NO_REPEAT_REQ: assert property (@(posedge clk) disable iff (rst)
        rq_valid |=> !(rq_valid && rq_line == $past(rq_line))); // R4

    AST_FILL_TOGETHER: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && !cpu_stall && fill_valid &&
         fill_line == cpu_addr[AW-1:LWB]) |=> !rq_valid); // R10
endmodule

bind sbf_top sbf_chk #(.AW(AW), .LWB(LWB)) u_chk (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_stall(cpu_stall), .lk_own(lk_own),
    .rq_valid(rq_valid), .rq_line(rq_line),
    .fill_valid(fill_valid), .fill_line(fill_line)
);

// File: tb/sim_sbf_top.sv
module sim_sbf_top;
    localparam int K_IDLE = 0, K_STORE = 1, K_LOAD = 2, K_FILL = 3;
    localparam int NV = 24;
    // {kind[47:46], addr[45:38], data[37:6], be[5:2], exp_rq[1], exp_direct[0]}
    localparam logic [47:0] VEC [NV] = '{
        {2'd1, 8'h01, 32'h11111111, 4'hF, 1'b0, 1'b1},   // R2 owned store
        {2'd2, 8'h01, 32'h0,        4'h0, 1'b0, 1'b0},   // R2 read back
        {2'd1, 8'h20, 32'hAAAA0000, 4'hF, 1'b1, 1'b0},   // R3 first miss
        {2'd1, 8'h21, 32'h0000BBBB, 4'h3, 1'b0, 1'b0},   // R4 same line
        {2'd1, 8'h20, 32'h000000CC, 4'h1, 1'b0, 1'b0},   // R4 same word
        {2'd2, 8'h20, 32'h0,        4'h0, 1'b0, 1'b0},   // R5 youngest lane
        {2'd2, 8'h21, 32'h0,        4'h0, 1'b0, 1'b0},   // R5 mixed lanes
        {2'd1, 8'h14, 32'h12345678, 4'hF, 1'b1, 1'b0},   // R3 other line
        {2'd2, 8'h14, 32'h0,        4'h0, 1'b0, 1'b0},   // R5
        {2'd3, 8'h20, 32'h0,        4'h0, 1'b0, 1'b0},   // fill line 8
        {2'd0, 8'h00, 32'h0,        4'h0, 1'b0, 1'b0},
        {2'd2, 8'h20, 32'h0,        4'h0, 1'b0, 1'b0},   // R5 after fill
        {2'd0, 8'h00, 32'h0,        4'h0, 1'b0, 1'b0},
        {2'd0, 8'h00, 32'h0,        4'h0, 1'b0, 1'b0},
        {2'd0, 8'h00, 32'h0,        4'h0, 1'b0, 1'b0},
        {2'd0, 8'h00, 32'h0,        4'h0, 1'b0, 1'b0},
        {2'd0, 8'h00, 32'h0,        4'h0, 1'b0, 1'b0},
        {2'd0, 8'h00, 32'h0,        4'h0, 1'b0, 1'b0},
        {2'd2, 8'h21, 32'h0,        4'h0, 1'b0, 1'b0},   // R6 drained word
        {2'd3, 8'h14, 32'h0,        4'h0, 1'b0, 1'b0},   // fill line 5
        {2'd0, 8'h00, 32'h0,        4'h0, 1'b0, 1'b0},
        {2'd0, 8'h00, 32'h0,        4'h0, 1'b0, 1'b0},
        {2'd0, 8'h00, 32'h0,        4'h0, 1'b0, 1'b0},
        {2'd1, 8'h03, 32'h9ABCDEF0, 4'h6, 1'b0, 1'b1}    // R2 partial lanes
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic [7:0]  lk_addr;
    logic        lk_own;
    logic [31:0] lk_rdata;
    logic        cwr_en;
    logic [7:0]  cwr_addr;
    logic [31:0] cwr_data;
    logic [3:0]  cwr_be;
    logic        rq_valid;
    logic [5:0]  rq_line;
    logic        fill_valid = 1'b0;
    logic [5:0]  fill_line = '0;

    logic [31:0] bmem [256];
    logic [31:0] cmem [256];
    logic [31:0] refm [256];
    logic        own  [64];
    logic [7:0]  cwr_log [64];
    int          cwr_cnt = 0;
    int          n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    sbf_top u0 (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall), .lk_addr(lk_addr),
        .lk_own(lk_own), .lk_rdata(lk_rdata), .cwr_en(cwr_en),
        .cwr_addr(cwr_addr), .cwr_data(cwr_data), .cwr_be(cwr_be),
        .rq_valid(rq_valid), .rq_line(rq_line),
        .fill_valid(fill_valid), .fill_line(fill_line)
    );

    assign lk_own   = own[lk_addr[7:2]];
    assign lk_rdata = cmem[lk_addr];

    function automatic logic [31:0] lanes(input logic [31:0] old,
                                          input logic [31:0] nw,
                                          input logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    initial begin
        for (int a = 0; a < 256; a++) begin
            bmem[a] = {8'h5A, 8'(a), ~8'(a), 8'(a) ^ 8'h3C};
            cmem[a] = bmem[a];
            refm[a] = bmem[a];
        end
        for (int l = 0; l < 64; l++) own[l] = (l < 4);
    end

    // cache model and write log
    always @(posedge clk) begin
        if (fill_valid) begin
            for (int w = 0; w < 4; w++) cmem[{fill_line, 2'(w)}] <= bmem[{fill_line, 2'(w)}];
            own[fill_line] <= 1'b1;
        end
        if (!rst && cwr_en) begin
            cmem[cwr_addr] <= lanes(cmem[cwr_addr], cwr_data, cwr_be);
            cwr_log[cwr_cnt[5:0]] <= cwr_addr;
            cwr_cnt <= cwr_cnt + 1;
        end
    end

    task automatic chk(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cpu_req = 1'b0; cpu_we = 1'b0; fill_valid = 1'b0;
    endtask

    // at a negedge: present a store, retry on stall, return after accept edge
    task automatic put_store(input logic [7:0] a, input logic [31:0] d,
                             input logic [3:0] be, output int stalls);
        stalls = 0;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d; cpu_be = be;
        #5;
        while (cpu_stall) begin
            stalls++;
            @(negedge clk); #5;
        end
        @(posedge clk);
        refm[a] = lanes(refm[a], d, be);
    endtask

    task automatic wait_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); idle_inputs();
        end
    endtask

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int st;
        int base;
        int mism;
        repeat (3) @(negedge clk);
        chk(!cpu_stall && !rq_valid && !cwr_en, "R1 reset quiet", {29'd0, cpu_stall, rq_valid, cwr_en}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!rq_valid && !cwr_en, "R1 after reset", {30'd0, rq_valid, cwr_en}, 32'd0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic [1:0]  k;
            logic [7:0]  a;
            logic [31:0] d;
            logic [3:0]  be;
            k = VEC[v][47:46]; a = VEC[v][45:38]; d = VEC[v][37:6]; be = VEC[v][5:2];
            idle_inputs();
            if (k == 2'(K_STORE)) begin
                put_store(a, d, be, st);
                #1;
                if (VEC[v][0])
                    chk(cwr_en && cwr_addr == a && cwr_data == d && cwr_be == be,
                        "R2 direct write", {24'd0, cwr_addr}, {24'd0, a});
                else
                    chk(!(cwr_en && cwr_addr == a), "R3 store held in buffer",
                        {24'd0, cwr_addr}, {24'd0, a});
                @(negedge clk);
                chk(rq_valid == VEC[v][1] && (!rq_valid || rq_line == a[7:2]),
                    VEC[v][1] ? "R3 request" : "R4 no request",
                    {25'd0, rq_valid, rq_line}, {25'd0, VEC[v][1], a[7:2]});
            end else if (k == 2'(K_LOAD)) begin
                cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
                #5;
                chk(cpu_rdata == refm[a], "R5 load data", cpu_rdata, refm[a]);
                @(negedge clk);
            end else if (k == 2'(K_FILL)) begin
                fill_valid = 1'b1; fill_line = a[7:2];
                @(negedge clk);
            end else begin
                @(negedge clk);
            end
        end
        wait_idle(6);

        // R7: younger filled entry waits behind older unfilled one
        put_store(8'h24, 32'hDEAD0001, 4'hF, st);
        @(negedge clk); idle_inputs();
        put_store(8'h28, 32'hDEAD0002, 4'hF, st);
        @(negedge clk); idle_inputs();
        fill_valid = 1'b1; fill_line = 6'h0A;
        base = cwr_cnt;
        wait_idle(8);
        chk(cwr_cnt == base, "R7 no drain past unfilled head", 32'(cwr_cnt), 32'(base));
        fill_valid = 1'b1; fill_line = 6'h09;
        wait_idle(10);
        chk(cwr_cnt == base + 2 && cwr_log[base[5:0]] == 8'h24 && cwr_log[6'(base + 1)] == 8'h28,
            "R7 program order drain", {24'd0, cwr_log[base[5:0]]}, 32'h24);
        chk(cmem[8'h24] == refm[8'h24] && cmem[8'h28] == refm[8'h28], "R6 drained data",
            cmem[8'h28], refm[8'h28]);

        // R8: full buffer stalls stores, loads still served
        for (int i = 0; i < 4; i++) begin
            put_store(8'h30 + 8'(i), 32'hF0F0_0000 + 32'(i), 4'hF, st);
            @(negedge clk); idle_inputs();
        end
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h30; cpu_wdata = 32'h77777777; cpu_be = 4'hF;
        #5;
        chk(cpu_stall, "R8 stall when full", {31'd0, cpu_stall}, 32'd1);
        @(negedge clk); #5;
        chk(cpu_stall, "R8 stall held", {31'd0, cpu_stall}, 32'd1);
        @(negedge clk);
        cpu_we = 1'b0; cpu_addr = 8'h32;
        #5;
        chk(cpu_rdata == refm[8'h32], "R8 load while full", cpu_rdata, refm[8'h32]);
        @(negedge clk);
        fill_valid = 1'b1; fill_line = 6'h0C; cpu_req = 1'b0;
        @(negedge clk); fill_valid = 1'b0;
        put_store(8'h30, 32'h77777777, 4'hF, st);
        chk(st > 0, "R8 store waited for room", 32'(st), 32'd1);
        wait_idle(12);
        chk(cmem[8'h30] == refm[8'h30], "R6 newest value in cache", cmem[8'h30], refm[8'h30]);

        // R9: drain write and direct store in the same cycle
        put_store(8'h34, 32'hCAFE0034, 4'hF, st);
        @(negedge clk); idle_inputs();
        fill_valid = 1'b1; fill_line = 6'h0D;
        @(negedge clk); idle_inputs();
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h02; cpu_wdata = 32'h0BADF00D; cpu_be = 4'hF;
        #5;
        chk(cpu_stall && cwr_en && cwr_addr == 8'h34, "R9 drain wins port",
            {23'd0, cpu_stall, cwr_addr}, {23'd0, 1'b1, 8'h34});
        @(negedge clk); #5;
        chk(!cpu_stall && cwr_en && cwr_addr == 8'h02, "R9 store next cycle",
            {23'd0, cpu_stall, cwr_addr}, {23'd0, 1'b0, 8'h02});
        @(posedge clk);
        refm[8'h02] = lanes(refm[8'h02], 32'h0BADF00D, 4'hF);
        wait_idle(4);

        // R10: store arrives together with its line's fill
        put_store(8'h38, 32'h38383838, 4'hF, st);
        @(negedge clk);
        fill_valid = 1'b1; fill_line = 6'h0E;
        put_store(8'h39, 32'h39393939, 4'hF, st);
        @(negedge clk); idle_inputs();
        chk(!rq_valid, "R10 no request with fill", {31'd0, rq_valid}, 32'd0);
        wait_idle(8);
        chk(cmem[8'h39] == refm[8'h39] && cmem[8'h38] == refm[8'h38], "R10 drained",
            cmem[8'h39], refm[8'h39]);

        // R6: whole cache agrees with program order
        mism = 0;
        for (int a = 0; a < 256; a++) if (cmem[a] != refm[a]) mism++;
        chk(mism == 0, "R6 final cache image", 32'(mism), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule